// File: doc/BRIEF.md
# Tree Routing Cluster

This block is a single first-level cluster of a tree-shaped programmable fabric. It holds four small lookup-table leaves and two one-way routing stages. The downward stage is a row of small full crossbars that feed each leaf input. The upward stage is one full crossbar that collects the leaf outputs, sends them to the cluster outputs, and returns them as local feedback to the downward crossbars. Every select and every truth table comes from a single configuration shift chain.

The cluster is set up by holding the load enable high and shifting the bitstream in, most significant bit first. When the enable drops, the cluster computes on the user clock. No wire goes past this level. Leaves are interchangeable because every downward crossbar can reach the registered output of any leaf through the upward stage.

Top module: `tree_route_cluster`

## Requirements
- R1: A synchronous reset clears every configuration bit and every leaf register. The next cycle then shows cluOut = 0 and cfgOut = 0.
- R2: On each clock edge with cfgEn high, the chain shifts up one place, cfgIn enters bit 0, and cfgOut shows bit 123, so the first bit sent ends up at bit 123. While cfgEn is low the chain does not change. Bit map: leaf j truth table at bits 17j to 17j+15, leaf j mode bit at 17j+16, downward box d output j select (3 bits) at 68+3(4d+j), upward output k select (2 bits) at 116+2k.
- R3: While cfgEn is high, cluOut is 0 and every leaf register is cleared on each edge.
- R4: In combinational mode (mode bit 0), leaf j outputs the bit of its truth table at index {a3,a2,a1,a0}. Address bit d is output j of downward box d.
- R5: In registered mode (mode bit 1), leaf j outputs its register. The register captures the truth-table result on every clock edge.
- R6: In downward box d, select codes 0 to 3 pick cluster input 4d+code, code 4 picks feedback line d, and codes 5 to 7 give 0 whatever the inputs are.
- R7: cluOut[k] is the output of the leaf chosen by the 2-bit upward select k.
- R8: Feedback line d is the register of the leaf chosen by upward select d, never a combinational output. So any leaf reaches all four downward boxes, and a change on the inputs reaches the feedback only after a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | user and configuration clock |
| rst | input | 1 | synchronous reset, active high |
| cfgEn | input | 1 | configuration load enable |
| cfgIn | input | 1 | serial configuration data |
| cfgOut | output | 1 | tail of the configuration chain |
| cluIn | input | 16 | cluster input bus |
| cluOut | output | 4 | cluster output bus |

## Verification
On every cycle, the assertions check that reset clears the outputs and the leaf registers, that outputs stay at zero and registers are cleared during a load, and that the chain tail does not move while no load is in progress. The lookup function, the decoding of each select code (including the unused codes that give zero) and the registered feedback loop depend on the bitstream. Only the bench scenarios show them, by comparing each output sample with a reference model of the bit map.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;

  typedef struct packed {
    logic holdOut;
    logic clrRegs;
  } ctlStrobes_t;

  function automatic int cfgWidth(input int nLeaf, input int lutIn, input int cluIn);
    int dnIn;
    int dnSw;
    int upSw;
    dnIn = cluIn / lutIn + 1;
    dnSw = (dnIn > 1) ? $clog2(dnIn) : 1;
    upSw = (nLeaf > 1) ? $clog2(nLeaf) : 1;
    return nLeaf * ((1 << lutIn) + 1) + lutIn * nLeaf * dnSw + lutIn * upSw;
  endfunction

endpackage

// File: rtl/tree_route_xbar.sv
module tree_route_xbar #(
  parameter int N_IN  = 5,
  parameter int N_OUT = 4,
  localparam int SW   = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0]     din,
  input  logic [N_OUT*SW-1:0] sel,
  output logic [N_OUT-1:0]    dout
);

  logic [SW-1:0] code;

  always_comb begin
    code = '0;
    dout = '0;
    for (int o = 0; o < N_OUT; o++) begin
      code = sel[o*SW +: SW];
      if (int'(code) < N_IN) dout[o] = din[code];
      else                   dout[o] = 1'b0;
    end
  end

endmodule

// File: rtl/tree_route_leaf.sv
module tree_route_leaf #(
  parameter int LUT_IN = 4,
  localparam int LUT_BITS = 1 << LUT_IN
) (
  input  logic                clk,
  input  logic                clr,
  input  logic [LUT_BITS-1:0] truth,
  input  logic                regSel,
  input  logic [LUT_IN-1:0]   addr,
  output logic                q,
  output logic                y
);

  logic lutVal;

  assign lutVal = truth[addr];

  always_ff @(posedge clk) begin
    if (clr) q <= 1'b0;
    else     q <= lutVal;
  end

  assign y = regSel ? q : lutVal;

endmodule

// File: rtl/tree_route_ctrl.sv
module tree_route_ctrl import tree_route_pkg::*; #(
  parameter int CFG_W = 124
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgEn,
  input  logic             cfgIn,
  output logic [CFG_W-1:0] cfgWord,
  output logic             cfgOut,
  output ctlStrobes_t      ctl
);

  logic [CFG_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst)        chain <= '0;
    else if (cfgEn) chain <= {chain[CFG_W-2:0], cfgIn};
  end

  assign cfgWord     = chain;
  assign cfgOut      = chain[CFG_W-1];
  assign ctl.holdOut = cfgEn;
  assign ctl.clrRegs = rst | cfgEn;

endmodule

// File: rtl/tree_route_dp.sv
module tree_route_dp import tree_route_pkg::*; #(
  parameter int NLEAF   = 4,
  parameter int LUT_IN  = 4,
  parameter int CLU_IN  = 16,
  parameter int CLU_OUT = 4,
  localparam int CFG_W  = cfgWidth(NLEAF, LUT_IN, CLU_IN)
) (
  input  logic               clk,
  input  ctlStrobes_t        ctl,
  input  logic [CFG_W-1:0]   cfg,
  input  logic [CLU_IN-1:0]  cluIn,
  output logic [CLU_OUT-1:0] cluOut,
  output logic [NLEAF-1:0]   leafQ
);

  localparam int PER      = CLU_IN / LUT_IN;
  localparam int DN_IN    = PER + 1;
  localparam int DN_SW    = (DN_IN > 1) ? $clog2(DN_IN) : 1;
  localparam int UP_SW    = (NLEAF > 1) ? $clog2(NLEAF) : 1;
  localparam int LUT_BITS = 1 << LUT_IN;
  localparam int LEAF_CFG = LUT_BITS + 1;
  localparam int DN_BASE  = NLEAF * LEAF_CFG;
  localparam int UP_BASE  = DN_BASE + LUT_IN * NLEAF * DN_SW;

  logic [NLEAF-1:0]  leafY;
  logic [LUT_IN-1:0] fbLine;
  logic [LUT_IN-1:0] upY;
  logic [NLEAF-1:0]  dnY      [LUT_IN];
  logic [LUT_IN-1:0] leafAddr [NLEAF];

  for (genvar d = 0; d < LUT_IN; d++) begin : g_dn
    tree_route_xbar #(.N_IN(DN_IN), .N_OUT(NLEAF)) u_dn (
      .din  ({fbLine[d], cluIn[d*PER +: PER]}),
      .sel  (cfg[DN_BASE + d*NLEAF*DN_SW +: NLEAF*DN_SW]),
      .dout (dnY[d])
    );
  end

  for (genvar j = 0; j < NLEAF; j++) begin : g_leaf
    for (genvar d = 0; d < LUT_IN; d++) begin : g_addr
      assign leafAddr[j][d] = dnY[d][j];
    end
    tree_route_leaf #(.LUT_IN(LUT_IN)) u_leaf (
      .clk    (clk),
      .clr    (ctl.clrRegs),
      .truth  (cfg[j*LEAF_CFG +: LUT_BITS]),
      .regSel (cfg[j*LEAF_CFG + LUT_BITS]),
      .addr   (leafAddr[j]),
      .q      (leafQ[j]),
      .y      (leafY[j])
    );
  end

  tree_route_xbar #(.N_IN(NLEAF), .N_OUT(LUT_IN)) u_upOut (
    .din  (leafY),
    .sel  (cfg[UP_BASE +: LUT_IN*UP_SW]),
    .dout (upY)
  );

  tree_route_xbar #(.N_IN(NLEAF), .N_OUT(LUT_IN)) u_upFb (
    .din  (leafQ),
    .sel  (cfg[UP_BASE +: LUT_IN*UP_SW]),
    .dout (fbLine)
  );

  assign cluOut = ctl.holdOut ? '0 : upY[CLU_OUT-1:0];

endmodule

// File: rtl/tree_route_cluster.sv
module tree_route_cluster import tree_route_pkg::*; #(
  parameter int NLEAF   = 4,
  parameter int LUT_IN  = 4,
  parameter int CLU_IN  = 16,
  parameter int CLU_OUT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgEn,
  input  logic               cfgIn,
  output logic               cfgOut,
  input  logic [CLU_IN-1:0]  cluIn,
  output logic [CLU_OUT-1:0] cluOut
);

  localparam int CFG_W = cfgWidth(NLEAF, LUT_IN, CLU_IN);

  ctlStrobes_t      ctl;
  logic [CFG_W-1:0] cfgWord;
  logic [NLEAF-1:0] leafQ;

  tree_route_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cfgEn   (cfgEn),
    .cfgIn   (cfgIn),
    .cfgWord (cfgWord),
    .cfgOut  (cfgOut),
    .ctl     (ctl)
  );

  tree_route_dp #(
    .NLEAF(NLEAF), .LUT_IN(LUT_IN), .CLU_IN(CLU_IN), .CLU_OUT(CLU_OUT)
  ) u_dp (
    .clk    (clk),
    .ctl    (ctl),
    .cfg    (cfgWord),
    .cluIn  (cluIn),
    .cluOut (cluOut),
    .leafQ  (leafQ)
  );

endmodule

// File: rtl/tree_route_checker.sv
module tree_route_checker #(
  parameter int NLEAF   = 4,
  parameter int CLU_OUT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cfgEn,
  input logic               cfgOut,
  input logic [CLU_OUT-1:0] cluOut,
  input logic [NLEAF-1:0]   leafQ
);

  AST_RST_CLEARS_OUT: assert property (@(posedge clk) rst |=> cluOut == '0); // R1
  AST_RST_CLEARS_REGS: assert property (@(posedge clk) rst |=> leafQ == '0); // R1
  AST_CHAIN_FROZEN: assert property (@(posedge clk) disable iff (rst) !cfgEn |=> $stable(cfgOut)); // R2
  AST_LOAD_HOLDS_OUT: assert property (@(posedge clk) disable iff (rst) cfgEn |-> cluOut == '0); // R3
  AST_LOAD_CLEARS_REGS: assert property (@(posedge clk) disable iff (rst) cfgEn |=> leafQ == '0); // R3

endmodule

bind tree_route_cluster tree_route_checker #(.NLEAF(NLEAF), .CLU_OUT(CLU_OUT)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cfgEn  (cfgEn),
  .cfgOut (cfgOut),
  .cluOut (cluOut),
  .leafQ  (leafQ)
);

// File: tb/sim_tree_route_cluster.sv
`timescale 1ns/1ps
module sim_tree_route_cluster;

  localparam int CW  = 124;
  localparam int DNB = 68;
  localparam int UPB = 116;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgEn = 1'b0;
  logic        cfgIn = 1'b0;
  logic        cfgOut;
  logic [15:0] cluIn = '0;
  logic [3:0]  cluOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [CW-1:0] cur = '0;
  logic [3:0]    qM  = '0;

  always #2.5 clk = ~clk;

  tree_route_cluster u0 (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgIn(cfgIn),
    .cfgOut(cfgOut), .cluIn(cluIn), .cluOut(cluOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] putLeaf(logic [CW-1:0] c, int j, logic [15:0] t, logic r);
    c[j*17 +: 16] = t;
    c[j*17 + 16]  = r;
    return c;
  endfunction

  function automatic logic [CW-1:0] putDn(logic [CW-1:0] c, int d, int j, logic [2:0] code);
    c[DNB + (d*4 + j)*3 +: 3] = code;
    return c;
  endfunction

  function automatic logic [CW-1:0] putUp(logic [CW-1:0] c, int k, logic [1:0] code);
    c[UPB + 2*k +: 2] = code;
    return c;
  endfunction

  function automatic logic [3:0] mdlFb(logic [CW-1:0] c, logic [3:0] q);
    logic [3:0] fb;
    for (int k = 0; k < 4; k++) fb[k] = q[c[UPB + 2*k +: 2]];
    return fb;
  endfunction

  function automatic logic mdlLut(logic [CW-1:0] c, int j, logic [15:0] cin, logic [3:0] q);
    logic [3:0] fb;
    logic [3:0] a;
    logic [2:0] code;
    fb = mdlFb(c, q);
    for (int d = 0; d < 4; d++) begin
      code = c[DNB + (d*4 + j)*3 +: 3];
      if (code < 3'd4)       a[d] = cin[4*d + int'(code)];
      else if (code == 3'd4) a[d] = fb[d];
      else                   a[d] = 1'b0;
    end
    return c[j*17 + int'(a)];
  endfunction

  function automatic logic [3:0] mdlOut(logic [CW-1:0] c, logic [15:0] cin, logic [3:0] q);
    logic [3:0] o;
    int j;
    for (int k = 0; k < 4; k++) begin
      j = int'(c[UPB + 2*k +: 2]);
      o[k] = c[j*17 + 16] ? q[j] : mdlLut(c, j, cin, q);
    end
    return o;
  endfunction

  task automatic loadCfg(input logic [CW-1:0] v);
    for (int i = CW - 1; i >= 0; i--) begin
      @(negedge clk);
      cfgEn = 1'b1;
      cfgIn = v[i];
      if (i == CW - 2) begin
        #1 check("R2 chain tail after one shift", {31'd0, cfgOut}, {31'd0, cur[CW-2]});
      end
      if (i == CW / 2) begin
        cluIn = 16'($urandom);
        #1 check("R3 outputs held during load", {28'd0, cluOut}, 32'd0);
      end
    end
    @(negedge clk);
    cfgEn = 1'b0;
    cfgIn = 1'b0;
    cur = v;
    qM = '0;
    #1 check("R2 first bit at chain top", {31'd0, cfgOut}, {31'd0, v[CW-1]});
  endtask

  task automatic modelStep(input string tag);
    logic [3:0] exp;
    logic [3:0] nq;
    cluIn = 16'($urandom);
    #1;
    exp = mdlOut(cur, cluIn, qM);
    check(tag, {28'd0, cluOut}, {28'd0, exp});
    for (int j = 0; j < 4; j++) nq[j] = mdlLut(cur, j, cluIn, qM);
    @(negedge clk);
    qM = nq;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] cfgA;
    logic [CW-1:0] cfgB;
    logic [CW-1:0] cfgC;
    logic [CW-1:0] cfgR;
    int unsigned seed;
    seed = $urandom(32'd20240611);

    repeat (2) @(negedge clk);
    #1;
    check("R1 reset output", {28'd0, cluOut}, 32'd0);
    check("R1 reset chain tail", {31'd0, cfgOut}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R4 R6 R7: leaf j passes address bit 0, box 0 output j picks cluIn[j]
    cfgA = '0;
    for (int j = 0; j < 4; j++) begin
      cfgA = putLeaf(cfgA, j, 16'hAAAA, 1'b0);
      cfgA = putDn(cfgA, 0, j, 3'(j));
      for (int d = 1; d < 4; d++) cfgA = putDn(cfgA, d, j, 3'd7);
      cfgA = putUp(cfgA, j, 2'(j));
    end
    loadCfg(cfgA);
    cluIn = 16'h000A;
    #1 check("R4 R6 R7 pass-through A", {28'd0, cluOut}, 32'hA);
    @(negedge clk);
    cluIn = 16'hFFF5;
    #1 check("R4 R6 R7 pass-through 5", {28'd0, cluOut}, 32'h5);
    repeat (5) @(negedge clk);
    #1 check("R2 chain unchanged when idle", {31'd0, cfgOut}, {31'd0, cfgA[CW-1]});
    check("R2 function unchanged when idle", {28'd0, cluOut}, 32'h5);

    // R6: codes 5..7 give zero, inverted by the table
    cfgB = '0;
    for (int j = 0; j < 4; j++) begin
      cfgB = putLeaf(cfgB, j, 16'h5555, 1'b0);
      for (int d = 0; d < 4; d++) cfgB = putDn(cfgB, d, j, 3'(5 + (d + j) % 3));
      cfgB = putUp(cfgB, j, 2'(j));
    end
    loadCfg(cfgB);
    cluIn = 16'hFFFF;
    #1 check("R6 unused codes drive zero", {28'd0, cluOut}, 32'hF);

    // R5 R8: leaf 0 registered inverter fed back through code 4
    cfgC = '0;
    cfgC = putLeaf(cfgC, 0, 16'h5555, 1'b1);
    cfgC = putDn(cfgC, 0, 0, 3'd4);
    loadCfg(cfgC);
    cluIn = 16'h0000;
    #1 check("R3 R5 register cleared by load", {28'd0, cluOut}, 32'h0);
    @(negedge clk);
    #1 check("R5 R8 toggle to one", {28'd0, cluOut}, 32'hF);
    @(negedge clk);
    #1 check("R5 R8 toggle to zero", {28'd0, cluOut}, 32'h0);
    @(negedge clk);
    #1 check("R5 R8 toggle again", {28'd0, cluOut}, 32'hF);
    loadCfg(cfgC);
    #1 check("R3 reload clears register", {28'd0, cluOut}, 32'h0);
    @(negedge clk);
    #1 check("R5 running after reload", {28'd0, cluOut}, 32'hF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1 reset mid-run output", {28'd0, cluOut}, 32'h0);
    check("R1 reset mid-run chain", {31'd0, cfgOut}, 32'h0);
    cur = '0;
    qM = '0;

    // random bitstreams against the model
    for (int n = 0; n < 8; n++) begin
      for (int b = 0; b < CW; b++) cfgR[b] = 1'($urandom % 2);
      loadCfg(cfgR);
      for (int s = 0; s < 30; s++) modelStep("R4 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule